// File: doc/BRIEF.md
# Address-Masked GPIO Register Block

This block is an eight-pin general-purpose I/O port on an APB-style bus. It stores a per-pin direction bit and a per-pin output level. It passes the input pins through a two-stage synchronizer. The two register vectors drive the pins' output-enable and output-value lines directly.

The data register is reached through a whole window of word addresses. Address bits [9:2] of any access in that window form a bit mask. A write changes only the pins whose mask bit is set. A read returns zero in every unmasked position. Software can therefore set, clear or test one pin in a single access, with no read-modify-write. For pin n the access uses offset 1<<(n+2). Writing 1<<n drives that pin high, and writing 0 drives it low.

Direction is held in a separate plain register. Software updates it with an ordinary read-modify-write.

Top module: `mgpio_regs`

## Requirements
- R1: While rst_ni is low, and after it is released, the direction and output registers are 0, so gpio_oe_o=0 and gpio_out_o=0.
- R2: A write to offset 0x400 loads all eight bits of pwdata_i[7:0] into the direction register (1 = output). gpio_oe_o shows the new value after the write's clock edge, and a read of 0x400 returns it in full.
- R3: A write to any offset with paddr_i[11:10]=0 updates output bit k only when paddr_i[k+2] is 1. All other output bits keep their value.
- R4: A read with paddr_i[11:10]=0 returns 0 in every bit k for which paddr_i[k+2] is 0.
- R5: In a masked-in data read position, an output pin (direction bit 1) returns its driven output value. An input pin returns its synchronized input level.
- R6: A change on gpio_in_i becomes visible in data reads after exactly two rising clock edges.
- R7: Writing 1<<n at offset 1<<(n+2) sets only pin n high, and writing 0 there clears only pin n.
- R8: Reads of offsets that are neither in the data window nor 0x400 return 0, and writes to them change no register.
- R9: pready_o is always 1 and pslverr_o is always 0.
- R10: A register is written only in the access phase, with psel_i, penable_i and pwrite_i all high. A setup-phase cycle alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address inside the block |
| pwdata_i | input | 8 | Write data |
| prdata_o | output | 8 | Read data, combinational, 0 when not a selected read |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never an error |
| gpio_in_i | input | 8 | Asynchronous pin inputs |
| gpio_out_o | output | 8 | Output level per pin |
| gpio_oe_o | output | 8 | Output enable per pin |

## Verification
Register writes land on the rising edge that ends the access phase. The bench therefore checks gpio_out_o, gpio_oe_o and the read-back at the following falling edge. Read data is combinational from the address and the stored state, so it is sampled 1 ns after the access-phase address is driven, well away from any clock edge. Input levels need two rising edges before they appear. The synchronizer check reads immediately after driving a new level, then after one edge, then after two, and expects the old, old and new value in turn.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int unsigned NUM_PINS    = 8;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] DIR_OFFSET = 12'h400;

  typedef enum logic [1:0] {
    REGION_NONE = 2'd0,
    REGION_DATA = 2'd1,
    REGION_DIR  = 2'd2
  } region_e;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_decode.sv
module mgpio_decode
  import mgpio_pkg::*;
#(
  parameter int unsigned PINS = NUM_PINS,
  parameter int unsigned AW   = ADDR_W,
  parameter logic [AW-1:0] DIR_ADDR = DIR_OFFSET
) (
  input  logic [AW-1:0]   addr_i,
  output region_e         region_o,
  output logic [PINS-1:0] mask_o
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = PINS + 1;

  assign mask_o = addr_i[MASK_HI:MASK_LO];

  always_comb begin
    if (addr_i[AW-1:MASK_HI+1] == '0) region_o = REGION_DATA;
    else if (addr_i == DIR_ADDR)      region_o = REGION_DIR;
    else                              region_o = REGION_NONE;
  end
endmodule

// File: rtl/mgpio_store.sv
module mgpio_store #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_we_i,
  input  logic            data_we_i,
  input  logic [PINS-1:0] mask_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] out_o
);
  logic [PINS-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '0;
    else if (dir_we_i) dir_q <= wdata_i;
  end

  for (genvar k = 0; k < PINS; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     out_q[k] <= 1'b0;
      else if (data_we_i && mask_i[k]) out_q[k] <= wdata_i[k];
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int unsigned PINS = NUM_PINS,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned SYNC = SYNC_STAGES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            psel_i,
  input  logic            penable_i,
  input  logic            pwrite_i,
  input  logic [AW-1:0]   paddr_i,
  input  logic [PINS-1:0] pwdata_i,
  output logic [PINS-1:0] prdata_o,
  output logic            pready_o,
  output logic            pslverr_o,
  input  logic [PINS-1:0] gpio_in_i,
  output logic [PINS-1:0] gpio_out_o,
  output logic [PINS-1:0] gpio_oe_o
);
  region_e         region;
  logic [PINS-1:0] mask, dir, out_val, in_sync, pin_val;
  logic            wr_access;

  mgpio_decode #(.PINS(PINS), .AW(AW), .DIR_ADDR(DIR_OFFSET)) u_decode (
    .addr_i  (paddr_i),
    .region_o(region),
    .mask_o  (mask)
  );

  mgpio_sync #(.WIDTH(PINS), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(gpio_in_i),
    .sync_o (in_sync)
  );

  assign wr_access = psel_i && penable_i && pwrite_i;

  mgpio_store #(.PINS(PINS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_we_i (wr_access && (region == REGION_DIR)),
    .data_we_i(wr_access && (region == REGION_DATA)),
    .mask_i   (mask),
    .wdata_i  (pwdata_i),
    .dir_o    (dir),
    .out_o    (out_val)
  );

  // output pins read back their driven level, input pins their synchronized level
  assign pin_val = (dir & out_val) | (~dir & in_sync);

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      unique case (region)
        REGION_DATA: prdata_o = pin_val & mask;
        REGION_DIR:  prdata_o = dir;
        default:     prdata_o = '0;
      endcase
    end
  end

  assign pready_o   = 1'b1;
  assign pslverr_o  = 1'b0;
  assign gpio_out_o = out_val;
  assign gpio_oe_o  = dir;
endmodule

// File: rtl/mgpio_regs_chk.sv
module mgpio_regs_chk #(
  parameter int unsigned PINS = 8,
  parameter int unsigned AW   = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            psel_i,
  input logic            penable_i,
  input logic            pwrite_i,
  input logic [AW-1:0]   paddr_i,
  input logic [PINS-1:0] pwdata_i,
  input logic [PINS-1:0] prdata_o,
  input logic            pready_o,
  input logic            pslverr_o,
  input logic [PINS-1:0] gpio_out_o,
  input logic [PINS-1:0] gpio_oe_o
);
  logic            in_data, in_dir, full_wr;
  logic [PINS-1:0] amask;

  assign in_data = (paddr_i[AW-1:PINS+2] == '0);
  assign in_dir  = (paddr_i == AW'(12'h400));
  assign amask   = paddr_i[PINS+1:2];
  assign full_wr = psel_i && penable_i && pwrite_i;

  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gpio_out_o == '0) && (gpio_oe_o == '0));

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr && in_dir) |=> (gpio_oe_o == $past(pwdata_i)));

  p_masked_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr && in_data) |=>
      ((gpio_out_o & ~$past(amask)) == ($past(gpio_out_o) & ~$past(amask))) &&
      ((gpio_out_o & $past(amask)) == ($past(pwdata_i) & $past(amask))));

  p_read_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && in_data) |-> ((prdata_o & ~amask) == '0));

  p_unmapped_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && !in_data && !in_dir) |-> (prdata_o == '0));

  p_unmapped_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr && !in_data && !in_dir) |=> $stable(gpio_out_o) && $stable(gpio_oe_o));

  p_response_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  p_no_setup_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_wr |=> $stable(gpio_out_o) && $stable(gpio_oe_o));
endmodule

bind mgpio_regs mgpio_regs_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .prdata_o  (prdata_o),
  .pready_o  (pready_o),
  .pslverr_o (pslverr_o),
  .gpio_out_o(gpio_out_o),
  .gpio_oe_o (gpio_oe_o)
);

// File: tb/mgpio_regs_tb.sv
module mgpio_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [11:0] paddr_i = '0;
  logic [7:0]  pwdata_i = '0;
  logic [7:0]  prdata_o, gpio_out_o, gpio_oe_o;
  logic        pready_o, pslverr_o;
  logic [7:0]  gpio_in_i = 8'hA5;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mgpio_regs u_dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // both tasks start and end just after a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    psel_i = 1'b1; pwrite_i = 1'b1; penable_i = 1'b0; paddr_i = a; pwdata_i = d;
    @(negedge clk_i); penable_i = 1'b1;
    @(negedge clk_i); psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    psel_i = 1'b1; pwrite_i = 1'b0; penable_i = 1'b0; paddr_i = a;
    @(negedge clk_i); penable_i = 1'b1;
    #1 d = prdata_o;
    @(negedge clk_i); psel_i = 1'b0; penable_i = 1'b0;
  endtask

  // {is_read, addr[11:0], wdata[7:0], expected[7:0]}, gpio_in_i = A5
  localparam int NV = 19;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 12'h400, 8'h0F, 8'h00},  // R2 dir low nibble out
    {1'b1, 12'h400, 8'h00, 8'h0F},  // R2
    {1'b0, 12'h3FC, 8'h5A, 8'h00},  // R3 full mask
    {1'b1, 12'h3FC, 8'h00, 8'hAA},  // R5 mixed in/out
    {1'b0, 12'h00C, 8'hFF, 8'h00},  // R3 mask 03
    {1'b1, 12'h3FC, 8'h00, 8'hAB},  // R3
    {1'b1, 12'h3C0, 8'h00, 8'hA0},  // R4 mask F0
    {1'b1, 12'h000, 8'h00, 8'h00},  // R4 empty mask
    {1'b0, 12'h020, 8'h00, 8'h00},  // R7 clear pin 3
    {1'b1, 12'h020, 8'h00, 8'h00},  // R7
    {1'b1, 12'h3FC, 8'h00, 8'hA3},  // R7 others kept
    {1'b1, 12'h004, 8'h00, 8'h01},  // R7 pin 0 read
    {1'b0, 12'h800, 8'hFF, 8'h00},  // R8 unmapped write
    {1'b0, 12'h404, 8'hFF, 8'h00},  // R8 unmapped write
    {1'b1, 12'h3FC, 8'h00, 8'hA3},  // R8 data unchanged
    {1'b1, 12'h400, 8'h00, 8'h0F},  // R8 dir unchanged
    {1'b1, 12'h800, 8'h00, 8'h00},  // R8 unmapped read
    {1'b0, 12'h400, 8'hFF, 8'h00},  // R5 all outputs
    {1'b1, 12'h3FC, 8'h00, 8'h53}   // R5 output values
  };

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk_i);
    check("R1 oe in reset", gpio_oe_o, 8'h00);
    check("R1 out in reset", gpio_out_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 oe after reset", gpio_oe_o, 8'h00);
    check("R1 out after reset", gpio_out_o, 8'h00);
    bus_read(12'h400, rd);
    check("R1 dir readback", rd, 8'h00);
    check("R9 ready/err", {6'd0, pready_o, pslverr_o}, 8'h02);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        bus_read(VEC[i][27:16], rd);
        check($sformatf("vec %0d R2-5,7,8", i), rd, VEC[i][7:0]);
      end else begin
        bus_write(VEC[i][27:16], VEC[i][15:8]);
      end
    end
    check("R2 oe pins", gpio_oe_o, 8'hFF);
    check("R3 out pins", gpio_out_o, 8'h53);

    // R7 single pin set
    bus_write(12'h010, 8'h04);
    check("R7 set pin 2", gpio_out_o, 8'h57);
    bus_write(12'h010, 8'h00);
    check("R7 clear pin 2", gpio_out_o, 8'h53);

    // R10 setup phase only, then a read-type access phase
    psel_i = 1'b1; pwrite_i = 1'b1; penable_i = 1'b0; paddr_i = 12'h3FC; pwdata_i = 8'h00;
    @(negedge clk_i);
    pwrite_i = 1'b0; penable_i = 1'b1;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0;
    check("R10 out untouched", gpio_out_o, 8'h53);
    psel_i = 1'b0; penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = 12'h400;
    @(negedge clk_i);
    penable_i = 1'b0; pwrite_i = 1'b0;
    check("R10 oe untouched", gpio_oe_o, 8'hFF);

    // R6 synchronizer latency
    bus_write(12'h400, 8'h00);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = 12'h3FC;
    gpio_in_i = 8'h3C;
    #1 check("R6 edge 0", prdata_o, 8'hA5);
    @(negedge clk_i); #1 check("R6 edge 1", prdata_o, 8'hA5);
    @(negedge clk_i); #1 check("R6 edge 2", prdata_o, 8'h3C);
    psel_i = 1'b0;
    check("R9 ready/err end", {6'd0, pready_o, pslverr_o}, 8'h02);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule